// File: doc/BRIEF.md
# Pad Function Multiplexer with Drive-Mode Control

This block sits between a chip's internal logic and fourteen general-purpose pads. Software programs it through a small synchronous register port. For every pad it picks one of thirty-two sources as the value sent to the pad. Source zero is a software-owned data bit; sources 1 to 31 are internal function signals. A two-bit drive mode then decides when the pad's output enable is asserted. The levels arriving on the pads pass through a two-flop synchronizer and can be read back.

A few pads are fixed at elaboration. Pads 8 and 11 are reserved: they never drive, and they read back as invalid. Pad 9 can only be an input. Pads 0 and 1 are shared with a test port and may drive only after software releases them through a control bit. No software write can change these fixed properties.

Top module: `gpio_pad_mux`

## Requirements
- R1: After reset every drive field is 00, every data bit is 0, the release bit is 0, `padOe` is all zero, `padOut` is all zero, and reads of the select, drive, data and control registers return 0.
- R2: Pin n has a 5-bit source field at bits (n mod 6)*5 to (n mod 6)*5+4 of select register n/6, at addresses 0, 1 and 2. A field of 0 sends the pin's data bit to `padOut[n]`, and a field k from 1 to 31 sends `funcIn[k]`. `padOut` follows register writes from the cycle after the write edge, and it follows `funcIn` combinationally.
- R3: Pin n has a 2-bit drive field at bits 2n+1:2n of the drive register at address 4. 00 leaves the pin undriven, 01 drives it only while its value is 0, 10 drives it only while its value is 1, and 11 always drives it.
- R4: Pins 8 and 11 have `padOe` and `padOut` held at 0. Writes to their select, drive and data fields are ignored, and those fields read 0. Their bits in the input register always read 1.
- R5: Pin 9 is never driven. Its drive field reads 00, and a data write to it is ignored.
- R6: A write to address 5 updates a single data bit. Bits 4:0 give the pin index and bit 8 the new value. Every other pin keeps its bit, and an index of 14 or more changes nothing. A read of address 5 returns the data bits at bit n.
- R7: Pins 0 and 1 drive only while the release bit (bit 0 of address 7) is 1. That bit reads back at bit 0.
- R8: A read of address 6 returns the pad levels after two synchronizing flops. A level applied just before edge E is seen by reads issued at edge E+2 and later, and not by reads at E or E+1.
- R9: A read-enabled edge loads `regRdData`, which holds its value at every other edge. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstn | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, registered |
| funcIn | input | 32 | Internal function sources, index = select value |
| padIn | input | 14 | Pad levels in |
| padOut | output | 14 | Pad output values |
| padOe | output | 14 | Pad output enables |

## Verification
Pad outputs are due in the cycle after a register write edge, and a `funcIn` change shows at once. The bench samples them at the falling edge that follows each write, and after each `funcIn` change. Read data is due one cycle after a read-enabled edge. A scoreboard queue holds the expected word of each read, and a monitor compares it at the next falling edge. For the input path, reads are issued on three back-to-back edges after a pad change: the first two must return the old level and the third the new one.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int MAX_SEL_REGS = 4;
  localparam logic [ADDR_W-1:0] ADDR_DRIVE = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_DATA  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_INPUT = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd7;
  localparam int IDX_W   = 5;   // pin index field of a data write
  localparam int VAL_BIT = 8;   // value bit of a data write

  typedef enum logic [2:0] {
    RD_NONE, RD_SEL, RD_DRIVE, RD_DATA, RD_INPUT, RD_CTRL
  } rdSrc_e;

  typedef struct packed {
    logic       selWr;
    logic       driveWr;
    logic       dataWr;
    logic       ctrlWr;
    logic       rdStb;
    rdSrc_e     rdSrc;
    logic [1:0] regIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int NUM_SEL_REGS = 3
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe
);
  always_comb begin
    strobe        = '0;
    strobe.rdSrc  = RD_NONE;
    strobe.rdStb  = regRdEn;
    strobe.regIdx = regAddr[1:0];
    if (!regAddr[2]) begin
      if (int'(regAddr[1:0]) < NUM_SEL_REGS) begin
        strobe.selWr = regWrEn;
        strobe.rdSrc = RD_SEL;
      end
    end else begin
      case (regAddr)
        ADDR_DRIVE: begin strobe.driveWr = regWrEn; strobe.rdSrc = RD_DRIVE; end
        ADDR_DATA:  begin strobe.dataWr  = regWrEn; strobe.rdSrc = RD_DATA;  end
        ADDR_INPUT: strobe.rdSrc = RD_INPUT;
        default:    begin strobe.ctrlWr  = regWrEn; strobe.rdSrc = RD_CTRL;  end
      endcase
    end
  end
endmodule

// File: rtl/gpio_pad_datapath.sv
module gpio_pad_datapath
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS     = 14,
  parameter int SEL_W        = 5,
  parameter int PINS_PER_REG = 6,
  parameter logic [NUM_PINS-1:0] RSVD_MASK    = 14'h0900,
  parameter logic [NUM_PINS-1:0] IN_ONLY_MASK = 14'h0200,
  parameter logic [NUM_PINS-1:0] JTAG_MASK    = 14'h0003,
  localparam int FUNC_N = 2 ** SEL_W
) (
  input  logic                clk,
  input  logic                rstn,
  input  ctrlStrobe_t         strobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [FUNC_N-1:0]   funcIn,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [DATA_W-1:0]   rdData
);
  logic [SEL_W-1:0]    selField   [NUM_PINS];
  logic [1:0]          driveField [NUM_PINS];
  logic [NUM_PINS-1:0] dataBits;
  logic                jtagOff;
  logic [NUM_PINS-1:0] syncA, syncB;
  logic                unusedWr;

  assign unusedWr = ^wrData;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam bit IS_RSVD = RSVD_MASK[p];
    localparam bit IS_IN   = IN_ONLY_MASK[p];
    localparam bit IS_JTAG = JTAG_MASK[p];
    localparam int REG_IDX = p / PINS_PER_REG;
    localparam int SEL_LSB = (p % PINS_PER_REG) * SEL_W;
    logic [SEL_W-1:0] selQ;
    logic [1:0]       drvQ;
    logic             dataQ;
    logic             pinVal;
    logic             oeRaw;

    if (IS_RSVD) begin : g_sel_fixed
      assign selQ = '0;
    end else begin : g_sel_reg
      always_ff @(posedge clk) begin
        if (!rstn) selQ <= '0;
        else if (strobe.selWr && int'(strobe.regIdx) == REG_IDX)
          selQ <= wrData[SEL_LSB +: SEL_W];
      end
    end

    if (IS_RSVD || IS_IN) begin : g_out_fixed
      assign drvQ  = 2'b00;
      assign dataQ = 1'b0;
    end else begin : g_out_reg
      always_ff @(posedge clk) begin
        if (!rstn) begin
          drvQ  <= 2'b00;
          dataQ <= 1'b0;
        end else begin
          if (strobe.driveWr) drvQ <= wrData[2*p +: 2];
          if (strobe.dataWr && wrData[IDX_W-1:0] == IDX_W'(p))
            dataQ <= wrData[VAL_BIT];
        end
      end
    end

    assign pinVal = (selQ == '0) ? dataQ : funcIn[selQ];

    always_comb begin
      case (drvQ)
        2'b01:   oeRaw = ~pinVal;
        2'b10:   oeRaw = pinVal;
        2'b11:   oeRaw = 1'b1;
        default: oeRaw = 1'b0;
      endcase
    end

    if (IS_RSVD) begin : g_pad_rsvd
      assign padOut[p] = 1'b0;
      assign padOe[p]  = 1'b0;
    end else if (IS_IN) begin : g_pad_in
      assign padOut[p] = pinVal;
      assign padOe[p]  = 1'b0;
    end else if (IS_JTAG) begin : g_pad_jtag
      assign padOut[p] = pinVal;
      assign padOe[p]  = oeRaw & jtagOff;
    end else begin : g_pad_free
      assign padOut[p] = pinVal;
      assign padOe[p]  = oeRaw;
    end

    assign selField[p]   = selQ;
    assign driveField[p] = drvQ;
    assign dataBits[p]   = dataQ;
  end

  always_ff @(posedge clk) begin
    if (!rstn) begin
      jtagOff <= 1'b0;
      syncA   <= '0;
      syncB   <= '0;
    end else begin
      if (strobe.ctrlWr) jtagOff <= wrData[0];
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  logic [DATA_W-1:0] selWords [MAX_SEL_REGS];
  logic [DATA_W-1:0] drvWord;
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    for (int r = 0; r < MAX_SEL_REGS; r++) selWords[r] = '0;
    drvWord = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      selWords[p / PINS_PER_REG][(p % PINS_PER_REG) * SEL_W +: SEL_W] = selField[p];
      drvWord[2*p +: 2] = driveField[p];
    end
  end

  always_comb begin
    case (strobe.rdSrc)
      RD_SEL:   rdNext = selWords[strobe.regIdx];
      RD_DRIVE: rdNext = drvWord;
      RD_DATA:  rdNext = DATA_W'(dataBits);
      RD_INPUT: rdNext = DATA_W'(syncB | RSVD_MASK);
      RD_CTRL:  rdNext = DATA_W'(jtagOff);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstn) rdData <= '0;
    else if (strobe.rdStb) rdData <= rdNext;
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS     = 14,
  parameter int SEL_W        = 5,
  parameter int PINS_PER_REG = 6,
  parameter logic [NUM_PINS-1:0] RSVD_MASK    = 14'h0900,
  parameter logic [NUM_PINS-1:0] IN_ONLY_MASK = 14'h0200,
  parameter logic [NUM_PINS-1:0] JTAG_MASK    = 14'h0003
) (
  input  logic                  clk,
  input  logic                  rstn,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [2**SEL_W-1:0]   funcIn,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe
);
  localparam int NUM_SEL_REGS = (NUM_PINS + PINS_PER_REG - 1) / PINS_PER_REG;

  ctrlStrobe_t strobe;

  gpio_pad_ctrl #(.NUM_SEL_REGS(NUM_SEL_REGS)) u_ctrl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .strobe(strobe)
  );

  gpio_pad_datapath #(
    .NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .PINS_PER_REG(PINS_PER_REG),
    .RSVD_MASK(RSVD_MASK), .IN_ONLY_MASK(IN_ONLY_MASK), .JTAG_MASK(JTAG_MASK)
  ) u_dp (
    .clk(clk), .rstn(rstn), .strobe(strobe), .wrData(regWrData),
    .funcIn(funcIn), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .rdData(regRdData)
  );
endmodule

// File: rtl/gpio_pad_mux_chk.sv
module gpio_pad_mux_chk
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS = 14,
  parameter logic [NUM_PINS-1:0] RSVD_MASK    = 14'h0900,
  parameter logic [NUM_PINS-1:0] IN_ONLY_MASK = 14'h0200,
  parameter logic [NUM_PINS-1:0] JTAG_MASK    = 14'h0003
) (
  input logic                clk,
  input logic                rstn,
  input logic                regWrEn,
  input logic                regRdEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [DATA_W-1:0]   regWrData,
  input logic [DATA_W-1:0]   regRdData,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe
);
  logic relFlag;
  always_ff @(posedge clk) begin
    if (!rstn) relFlag <= 1'b0;
    else if (regWrEn && regAddr == ADDR_CTRL) relFlag <= regWrData[0];
  end

  p_rsvd_quiet_r4: assert property (@(posedge clk) disable iff (!rstn)
    ((padOe | padOut) & RSVD_MASK) == '0);

  p_input_only_r5: assert property (@(posedge clk) disable iff (!rstn)
    (padOe & IN_ONLY_MASK) == '0);

  p_jtag_hold_r7: assert property (@(posedge clk) disable iff (!rstn)
    ((padOe & JTAG_MASK) != '0) |-> relFlag);

  p_drive_clear_r3: assert property (@(posedge clk) disable iff (!rstn)
    (regWrEn && regAddr == ADDR_DRIVE && regWrData == '0) |=> (padOe == '0));

  p_read_hold_r9: assert property (@(posedge clk) disable iff (!rstn)
    !regRdEn |=> $stable(regRdData));
endmodule

bind gpio_pad_mux gpio_pad_mux_chk #(
  .NUM_PINS(NUM_PINS), .RSVD_MASK(RSVD_MASK),
  .IN_ONLY_MASK(IN_ONLY_MASK), .JTAG_MASK(JTAG_MASK)
) u_chk (
  .clk(clk), .rstn(rstn), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
  .padOut(padOut), .padOe(padOe)
);

// File: tb/gpio_pad_mux_bench.sv
module gpio_pad_mux_bench;
  localparam int NP = 14;

  logic        clk = 1'b0, rstn = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic [31:0] funcIn = '0;
  logic [NP-1:0] padIn = '0, padOut, padOe;

  always #5 clk = ~clk;

  gpio_pad_mux u_gpio_pad_mux (
    .clk(clk), .rstn(rstn), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .funcIn(funcIn), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  // requirement model
  logic [4:0]    mSel [NP];
  logic [1:0]    mDrv [NP];
  logic [NP-1:0] mData;
  logic          mRel;

  function automatic bit isRsvd(int p); return p == 8 || p == 11; endfunction
  function automatic bit isInOnly(int p); return p == 9; endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(logic [2:0] a, logic [31:0] d);
    case (a)
      3'd0, 3'd1, 3'd2:
        for (int p = 0; p < NP; p++)
          if (p / 6 == int'(a) && !isRsvd(p)) mSel[p] = d[(p % 6) * 5 +: 5];
      3'd4:
        for (int p = 0; p < NP; p++)
          if (!isRsvd(p) && !isInOnly(p)) mDrv[p] = d[2*p +: 2];
      3'd5:
        if (int'(d[4:0]) < NP && !isRsvd(int'(d[4:0])) && !isInOnly(int'(d[4:0])))
          mData[d[4:0]] = d[8];
      3'd7: mRel = d[0];
      default: ;
    endcase
  endtask

  function automatic logic [31:0] selWord(int r);
    logic [31:0] w = '0;
    for (int p = 0; p < NP; p++) if (p / 6 == r) w[(p % 6) * 5 +: 5] = mSel[p];
    return w;
  endfunction

  function automatic logic [31:0] drvWord();
    logic [31:0] w = '0;
    for (int p = 0; p < NP; p++) w[2*p +: 2] = mDrv[p];
    return w;
  endfunction

  task automatic checkPads(string tag);
    logic [NP-1:0] eo, ee;
    for (int p = 0; p < NP; p++) begin
      logic v, oe;
      v = (mSel[p] == 0) ? mData[p] : funcIn[mSel[p]];
      case (mDrv[p])
        2'b01: oe = ~v;
        2'b10: oe = v;
        2'b11: oe = 1'b1;
        default: oe = 1'b0;
      endcase
      if (isRsvd(p) || isInOnly(p) || (p < 2 && !mRel)) oe = 1'b0;
      eo[p] = isRsvd(p) ? 1'b0 : v;
      ee[p] = oe;
    end
    check({tag, " padOut"}, 32'(padOut), 32'(eo));
    check({tag, " padOe"}, 32'(padOe), 32'(ee));
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    modelWrite(a, d);
    checkPads(tag);
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // monitor: compares read data one cycle after each read-enabled edge
  logic rdPend = 1'b0;
  always @(posedge clk) rdPend <= regRdEn;
  always @(negedge clk) begin
    if (rdPend) begin
      if (expQ.size() == 0) check("R9 unexpected read", regRdData, 32'hDEAD_BEEF);
      else check(tagQ.pop_front(), regRdData, expQ.pop_front());
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic [NP-1:0] oldIn;
    for (int p = 0; p < NP; p++) begin mSel[p] = '0; mDrv[p] = '0; end
    mData = '0; mRel = 1'b0;
    repeat (4) @(negedge clk);
    rstn = 1'b1;
    @(negedge clk);
    checkPads("R1 reset pads");
    rd(3'd0, 32'h0, "R1 reset select 0");
    rd(3'd4, 32'h0, "R1 reset drive");
    rd(3'd5, 32'h0, "R1 reset data");
    rd(3'd7, 32'h0, "R1 reset release");
    rd(3'd6, 32'h0000_0900, "R4 R8 reset input");

    // all pins drive-always, test pins not released yet
    wr(3'd4, 32'h0FFF_FFFF, "R7 drive all, unreleased");
    rd(3'd4, 32'h0F30_FFFF, "R4 R5 drive readback");
    wr(3'd7, 32'h1, "R7 released");
    rd(3'd7, 32'h1, "R7 release readback");

    // function sources
    funcIn = 32'hA5A5_5A5A;
    d = 0;
    for (int i = 0; i < 6; i++) d[i*5 +: 5] = 5'(i + 1);
    wr(3'd0, d, "R2 select reg 0");
    rd(3'd0, selWord(0), "R2 select 0 readback");
    wr(3'd1, 32'h3FFF_FFFF, "R2 R4 select reg 1 all 31");
    rd(3'd1, selWord(1), "R4 select 1 readback");
    wr(3'd2, 32'h0000_03E0, "R2 select reg 2");
    rd(3'd2, selWord(2), "R2 select 2 readback");
    @(negedge clk); funcIn = 32'h5A5A_A5A5;
    #1 checkPads("R2 funcIn change");
    @(negedge clk); funcIn = 32'h7FFF_FFFF;
    #1 checkPads("R2 source 31 low");

    // data bits
    wr(3'd0, 32'h0, "R2 select 0 to data");
    wr(3'd5, 32'h0000_0103, "R6 set pin 3");
    rd(3'd5, 32'h0000_0008, "R6 data readback");
    wr(3'd5, 32'h0000_0108, "R4 data pin 8 ignored");
    wr(3'd5, 32'h0000_0109, "R5 data pin 9 ignored");
    wr(3'd5, 32'h0000_0114, "R6 index 20 ignored");
    rd(3'd5, 32'h0000_0008, "R4 R5 R6 data unchanged");
    wr(3'd5, 32'h0000_010C, "R6 set pin 12");
    wr(3'd5, 32'h0000_0003, "R6 clear pin 3");
    rd(3'd5, 32'h0000_1000, "R6 only pin 3 changed");

    // drive modes
    d = 32'h0FFF_FFFF;
    d[5:4] = 2'b01; d[7:6] = 2'b10; d[9:8] = 2'b11; d[11:10] = 2'b00;
    wr(3'd5, 32'h0000_0102, "R3 pin 2 high");
    wr(3'd4, d, "R3 mixed modes, pin2=1 pin3=0");
    wr(3'd5, 32'h0000_0002, "R3 pin 2 low");
    wr(3'd5, 32'h0000_0103, "R3 pin 3 high");
    wr(3'd5, 32'h0000_0105, "R3 pin 5 high, undriven");
    wr(3'd7, 32'h0, "R7 re-hold test pins");
    wr(3'd4, 32'h0, "R3 drive cleared");

    // input synchronizer latency
    oldIn = padIn;
    @(negedge clk);
    padIn = 14'h2A5A; regRdEn = 1'b1; regAddr = 3'd6;
    expQ.push_back(32'(oldIn | 14'h0900)); tagQ.push_back("R8 first edge old");
    @(negedge clk);
    expQ.push_back(32'(oldIn | 14'h0900)); tagQ.push_back("R8 second edge old");
    @(negedge clk);
    expQ.push_back(32'(14'h2A5A | 14'h0900)); tagQ.push_back("R8 third edge new");
    @(negedge clk);
    regRdEn = 1'b0;

    // read port behaviour
    rd(3'd3, 32'h0, "R9 unmapped address");
    rd(3'd7, 32'h0, "R7 release cleared");
    regAddr = 3'd4;
    repeat (2) @(negedge clk);
    check("R9 read data held", regRdData, 32'h0);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule